// File: doc/BRIEF.md
# One-Second Tick Generator

This block turns one of four timing references into a single-cycle strobe once per second, in the system clock domain. A static two-bit select picks the reference. It can be a slow watch crystal divided by a power of two, a fast crystal divided by a larger power of two, a mains zero-crossing pulse train counted to 120 or 100 depending on the grid setting, or an active-low one-pulse-per-second reference from outside.

Every reference passes through a two-flop synchroniser. The zero-cross and external inputs then go through a level filter that accepts a new level only after it has held for a set number of system clocks. This means a noisy or bouncing edge yields exactly one counted event. A single counter, shared by all sources, advances on the accepted edges of the selected source. It fires the strobe when it reaches that source's terminal count. Changing the source select or the grid setting restarts the count.

Top module: `sec_tick_gen`

## Requirements
- R1: With `srcSel` = 0 (slow crystal), `tick` pulses once for every 2^SLOW_EXP rising edges on `xtalSlow` (default 2^15).
- R2: With `srcSel` = 1 (fast crystal), `tick` pulses once for every 2^FAST_EXP rising edges on `xtalFast` (default 2^22).
- R3: With `srcSel` = 2 (mains) and `grid60` = 1, `tick` pulses once for every 120 accepted rising edges on `zeroCross`.
- R4: With `srcSel` = 2 and `grid60` = 0, `tick` pulses once for every 100 accepted rising edges on `zeroCross`.
- R5: With `srcSel` = 3 (external), each accepted falling edge of `extRefN` gives exactly one tick, and a rising edge gives none.
- R6: On `zeroCross` and `extRefN`, a level that holds for fewer than FILT_LEN system clocks after synchronisation is ignored. A level that holds for FILT_LEN clocks is accepted once, so a bouncing edge counts as one edge.
- R7: A change of `srcSel` or `grid60` clears the count. The first tick after the change needs a full period of edges of the new setting, and `tick` stays low in the cycle after the change is seen.
- R8: `tick` is high for exactly one clock cycle, and only in the cycle that follows an accepted edge of the selected source.
- R9: During reset `tick` is low. Reset clears the count, so after reset a full period of edges is needed before the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 2 | Reference select: 0 slow crystal, 1 fast crystal, 2 mains, 3 external |
| grid60 | input | 1 | Mains grid setting: 1 for 60 Hz (120 crossings), 0 for 50 Hz (100 crossings) |
| xtalSlow | input | 1 | Slow crystal clock, sampled |
| xtalFast | input | 1 | Fast crystal clock, sampled |
| zeroCross | input | 1 | Mains zero-crossing pulse, one pulse per crossing |
| extRefN | input | 1 | External one-per-second reference, active low |
| tick | output | 1 | One-clock-wide one-second strobe |

## Verification
The bench targets a glitch shorter than the filter window, and a bounce just before a real external edge. A design with a weak filter would add a second, or count the bounce twice. It stops one edge short of each terminal count, including the 99th of 100 mains crossings. A design with an off-by-one ratio would tick early there. It also switches source and grid setting partway through a count, and resets partway through a count. A design that kept the old count would tick early or wrap through its full range. Finally, it drives external pulses whose trailing rising edge must not tick, and it watches for any strobe wider than one cycle.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    SRC_XTAL_SLOW = 2'd0,
    SRC_XTAL_FAST = 2'd1,
    SRC_MAINS     = 2'd2,
    SRC_EXT       = 2'd3
  } src_e;

  localparam int NUM_SRC = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // count one accepted edge of the selected source
    logic restart;  // clear the count (selection changed)
  } tick_ctl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edge_conditioner.sv
module edge_conditioner #(
  parameter int FILT_LEN   = 2500,
  parameter bit USE_FILTER = 1'b1,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic edgeOut
);

  localparam logic IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;
  localparam int   FW       = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0] syncQ;
  logic       syncd;
  logic       stableLvl;
  logic       take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= {2{IDLE_LVL}};
    else       syncQ <= {syncQ[0], rawIn};
  end
  assign syncd = syncQ[1];

  generate
    if (USE_FILTER) begin : g_filt
      logic [FW-1:0] holdCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               holdCnt <= '0;
        else if (syncd == stableLvl)             holdCnt <= '0;
        else if (holdCnt == FW'(FILT_LEN - 1))   holdCnt <= '0;
        else                                     holdCnt <= holdCnt + 1'b1;
      end
      assign take = (syncd != stableLvl) && (holdCnt == FW'(FILT_LEN - 1));
    end else begin : g_raw
      assign take = (syncd != stableLvl);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableLvl <= IDLE_LVL;
      edgeOut   <= 1'b0;
    end else begin
      if (take) stableLvl <= syncd;
      edgeOut <= take && (syncd != IDLE_LVL);
    end
  end

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int SLOW_EXP    = 15,
  parameter int FAST_EXP    = 22,
  parameter int MAINS60_DIV = 120,
  parameter int MAINS50_DIV = 100,
  parameter int CNT_W       = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           srcSel,
  input  logic                 grid60,
  input  logic [NUM_SRC-1:0]   chanEdge,
  output tick_ctl_t            ctl,
  output logic [CNT_W-1:0]     lastCount
);

  logic [1:0] prevSel;
  logic       prevGrid;
  logic       selEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel  <= SRC_XTAL_SLOW;
      prevGrid <= 1'b1;
    end else begin
      prevSel  <= srcSel;
      prevGrid <= grid60;
    end
  end

  always_comb begin
    selEdge = chanEdge[srcSel];
    unique case (srcSel)
      SRC_XTAL_SLOW: lastCount = CNT_W'((64'd1 << SLOW_EXP) - 64'd1);
      SRC_XTAL_FAST: lastCount = CNT_W'((64'd1 << FAST_EXP) - 64'd1);
      SRC_MAINS:     lastCount = grid60 ? CNT_W'(MAINS60_DIV - 1)
                                        : CNT_W'(MAINS50_DIV - 1);
      default:       lastCount = '0;
    endcase
    ctl.restart = (srcSel != prevSel) || (grid60 != prevGrid);
    ctl.advance = selEdge && !ctl.restart;
  end

endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  tick_ctl_t        ctl,
  input  logic [CNT_W-1:0] lastCount,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (ctl.restart) begin
        cnt <= '0;
      end else if (ctl.advance) begin
        if (cnt == lastCount) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sec_tick_gen.sv
module sec_tick_gen
  import tick_pkg::*;
#(
  parameter int SLOW_EXP    = 15,
  parameter int FAST_EXP    = 22,
  parameter int MAINS60_DIV = 120,
  parameter int MAINS50_DIV = 100,
  parameter int FILT_LEN    = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] srcSel,
  input  logic       grid60,
  input  logic       xtalSlow,
  input  logic       xtalFast,
  input  logic       zeroCross,
  input  logic       extRefN,
  output logic       tick
);

  localparam int MAX_DIV = maxOf(maxOf(1 << SLOW_EXP, 1 << FAST_EXP),
                                 maxOf(MAINS60_DIV, MAINS50_DIV));
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic [NUM_SRC-1:0] rawVec;
  logic [NUM_SRC-1:0] chanEdge;
  tick_ctl_t          ctl;
  logic [CNT_W-1:0]   lastCount;

  assign rawVec = {extRefN, zeroCross, xtalFast, xtalSlow};

  // Channels 0,1 are clean crystals; 2,3 are filtered; 3 is active low
  generate
    for (genvar ch = 0; ch < NUM_SRC; ch++) begin : g_chan
      edge_conditioner #(
        .FILT_LEN  (FILT_LEN),
        .USE_FILTER(ch >= 2),
        .ACTIVE_LOW(ch == 3)
      ) u_cond (
        .clk    (clk),
        .rstN   (rstN),
        .rawIn  (rawVec[ch]),
        .edgeOut(chanEdge[ch])
      );
    end
  endgenerate

  tick_ctrl #(
    .SLOW_EXP   (SLOW_EXP),
    .FAST_EXP   (FAST_EXP),
    .MAINS60_DIV(MAINS60_DIV),
    .MAINS50_DIV(MAINS50_DIV),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcSel   (srcSel),
    .grid60   (grid60),
    .chanEdge (chanEdge),
    .ctl      (ctl),
    .lastCount(lastCount)
  );

  tick_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .lastCount(lastCount),
    .tick     (tick)
  );

endmodule

// File: rtl/tick_checker.sv
module tick_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic [1:0] srcSel,
  input logic       advance,
  input logic       restart,
  input logic       extEdge
);

  // R8: strobe is one cycle wide
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R8: strobe only follows an accepted edge
  a_r8_follows_edge: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(advance));

  // R7: no strobe right after a selection change
  a_r7_restart_silent: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !tick);

  // R5: in external mode a tick comes from an accepted falling edge
  a_r5_ext_from_fall: assert property (@(posedge clk) disable iff (!rstN)
    (tick && srcSel == 2'd3 && $past(srcSel) == 2'd3) |-> $past(extEdge));

endmodule

bind sec_tick_gen tick_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .tick   (tick),
  .srcSel (srcSel),
  .advance(ctl.advance),
  .restart(ctl.restart),
  .extEdge(chanEdge[3])
);

// File: tb/sec_tick_gen_tb.sv
`timescale 1ns/1ps
module sec_tick_gen_tb;

  localparam int SLOW_EXP = 3;   // 8 edges per tick
  localparam int FAST_EXP = 4;   // 16 edges per tick
  localparam int FILT_LEN = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] srcSel = 2'd0;
  logic       grid60 = 1'b1;
  logic       xtalSlow = 1'b0;
  logic       xtalFast = 1'b0;
  logic       zeroCross = 1'b0;
  logic       extRefN = 1'b1;
  logic       tick;

  int nChecks = 0;
  int nFail = 0;
  int tickCount = 0;
  int widthErr = 0;
  logic prevTick = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sec_tick_gen #(
    .SLOW_EXP(SLOW_EXP), .FAST_EXP(FAST_EXP),
    .MAINS60_DIV(120), .MAINS50_DIV(100), .FILT_LEN(FILT_LEN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .grid60(grid60),
    .xtalSlow(xtalSlow), .xtalFast(xtalFast), .zeroCross(zeroCross),
    .extRefN(extRefN), .tick(tick)
  );

  always @(negedge clk) begin
    if (tick) tickCount <= tickCount + 1;
    if (tick && prevTick) widthErr <= widthErr + 1;
    prevTick <= tick;
  end

  // {sel[1:0], grid, edges[7:0], expected ticks[3:0]}
  localparam logic [14:0] VECS [8] = '{
    {2'd0, 1'b1, 8'd8,   4'd1},  // R1
    {2'd0, 1'b1, 8'd16,  4'd2},  // R1
    {2'd1, 1'b1, 8'd16,  4'd1},  // R2
    {2'd1, 1'b1, 8'd15,  4'd0},  // R2 one short
    {2'd2, 1'b1, 8'd120, 4'd1},  // R3 (switch from partial count, R7)
    {2'd2, 1'b0, 8'd100, 4'd1},  // R4 (grid change restarts)
    {2'd2, 1'b0, 8'd99,  4'd0},  // R4 one short
    {2'd3, 1'b0, 8'd3,   4'd3}   // R5
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int ch, input logic active);
    case (ch)
      0: xtalSlow  = active;
      1: xtalFast  = active;
      2: zeroCross = active;
      default: extRefN = ~active;
    endcase
  endtask

  task automatic pulses(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      drive(ch, 1'b1);
      repeat (8) @(negedge clk);
      drive(ch, 1'b0);
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic glitch(input int ch, input int width);
    drive(ch, 1'b1);
    repeat (width) @(negedge clk);
    drive(ch, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic selectSrc(input logic [1:0] s, input logic g);
    srcSel = s;
    grid60 = g;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R9 tick low in reset", int'(tick), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 tick low after reset", int'(tick), 0);

    // Table walk
    for (int v = 0; v < 8; v++) begin
      logic [14:0] vec;
      vec = VECS[v];
      selectSrc(vec[14:13], vec[12]);
      base = tickCount;
      pulses(int'(vec[14:13]), int'(vec[11:4]));
      settle();
      check($sformatf("R1-R5 table vector %0d (R1 R2 R3 R4 R5)", v),
            tickCount - base, int'(vec[3:0]));
    end

    // R5: rising edge of extRefN alone gives no tick
    selectSrc(2'd3, 1'b1);
    extRefN = 1'b0;
    repeat (10) @(negedge clk);
    base = tickCount;
    extRefN = 1'b1;
    settle();
    check("R5 rising edge ignored", tickCount - base, 0);

    // R6: short glitch on external reference ignored
    base = tickCount;
    glitch(3, 2);
    settle();
    check("R6 external glitch ignored", tickCount - base, 0);

    // R6: bounce before a real falling edge counts once
    base = tickCount;
    extRefN = 1'b0; repeat (2) @(negedge clk);
    extRefN = 1'b1; repeat (2) @(negedge clk);
    extRefN = 1'b0; repeat (10) @(negedge clk);
    extRefN = 1'b1;
    settle();
    check("R6 bounced edge counted once", tickCount - base, 1);

    // R6: glitches between mains crossings are not counted
    selectSrc(2'd2, 1'b1);
    base = tickCount;
    for (int i = 0; i < 119; i++) begin
      pulses(2, 1);
      if (i % 10 == 0) glitch(2, 3);
    end
    settle();
    check("R6 mains 119 edges plus glitches", tickCount - base, 0);
    pulses(2, 1);
    settle();
    check("R6 mains 120th edge", tickCount - base, 1);

    // R7: switch mid-count from fast crystal to slow crystal
    selectSrc(2'd1, 1'b1);
    pulses(1, 10);
    selectSrc(2'd0, 1'b1);
    base = tickCount;
    pulses(0, 7);
    settle();
    check("R7 no early tick after switch", tickCount - base, 0);
    pulses(0, 1);
    settle();
    check("R7 full period after switch", tickCount - base, 1);

    // R9: reset mid-count clears the count
    pulses(0, 5);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 tick low in mid-count reset", int'(tick), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    base = tickCount;
    pulses(0, 7);
    settle();
    check("R9 no early tick after reset", tickCount - base, 0);
    pulses(0, 1);
    settle();
    check("R9 full period after reset", tickCount - base, 1);

    check("R8 tick one cycle wide", widthErr, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule